// File: doc/BRIEF.md
# Listen-Time Normalized Immunity Evaluator

This block makes the periodic immunity decision for a receiver front end. On each evaluation it adds the listen milliseconds reported since the previous evaluation to a running listen-time total. When automatic control is enabled, it scales four per-second error rates by that total to form error limits. It then compares the OFDM and CCK timing-error counts of the current period against those limits. The result is a single-cycle raise pulse, with a flag that says whether OFDM errors were the cause, or a single-cycle lower pulse. Either pulse is accompanied by a period-restart pulse.

Evaluations are requested by a strobe. The strobe arrives from a roughly once-per-second timer and also whenever an error trigger fires. Each limit is `floor(listen_total * rate / 1000)`, computed by a shared multi-cycle divider. The block holds `busy_o` high for the whole evaluation and drops any strobe that arrives in that time. When a period restarts, the listen total and the two error counts are kept as snapshots, and the listen total is cleared. The external error counters are expected to clear on the restart pulse.

Top module: `immunity_eval`

## Requirements
- R1: After reset, busy, every pulse output and all three snapshot outputs are zero.
- R2: A strobe accepted while idle adds `listen_ms_i` to the listen total, also when `auto_en_i` is low. With `auto_en_i` low, the block raises no pulse and does not go busy.
- R3: With `auto_en_i` high, the four limits are `floor(T*rate/1000)`, where T is the listen total including the new listen time. The rates are OFDM-high, CCK-high, OFDM-low and CCK-low.
- R4: A raise pulse fires when the OFDM count exceeds the OFDM-high limit or the CCK count exceeds the CCK-high limit. `raise_ofdm_o` is 1 exactly when the OFDM count exceeded its high limit.
- R5: If there is no raise and T exceeds `QUIET_PERIODS*LISTEN_PERIOD_MS`, the period restarts. A lower pulse fires only if the OFDM count is at or below its low limit and the CCK count is at or below its low limit.
- R6: If there is no raise and T does not exceed the quiet window, no pulse fires, the listen total is kept, and the snapshots do not change.
- R7: On a restart, the snapshots take the listen total T and the OFDM and CCK counts sampled with the strobe, and the listen total becomes zero.
- R8: An automatic evaluation holds `busy_o` high from the cycle after the strobe until the decision cycle. A strobe seen while busy is ignored and adds nothing to the listen total.
- R9: The pulses last one cycle. Raise and lower never fire together, and restart fires in the same cycle as any raise or lower.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eval_strobe_i | input | 1 | Request one evaluation |
| listen_ms_i | input | LISTEN_W | Listen milliseconds since the previous evaluation |
| ofdm_err_i | input | ERR_W | OFDM timing errors in the current period |
| cck_err_i | input | ERR_W | CCK timing errors in the current period |
| auto_en_i | input | 1 | Automatic immunity control enabled |
| busy_o | output | 1 | Evaluation in progress; strobes are dropped |
| raise_o | output | 1 | Pulse: raise immunity |
| raise_ofdm_o | output | 1 | With raise_o: OFDM errors caused the raise |
| lower_o | output | 1 | Pulse: lower immunity |
| restart_o | output | 1 | Pulse: new period begins |
| snap_listen_o | output | ACC_W | Listen total held at the last restart |
| snap_ofdm_o | output | ERR_W | OFDM count held at the last restart |
| snap_cck_o | output | ERR_W | CCK count held at the last restart |

## Verification
The bench chooses counts one below, at and one above each computed limit, because the limits are floored quotients. A strict-versus-inclusive slip or a truncation error in the divider therefore flips a raise or lower on a single count. Listen times are chosen so that the total sometimes lands just inside and sometimes just past the quiet window. A design that tested the new listen time instead of the total, or that cleared the total without a restart, then restarts at the wrong evaluation, and the snapshots show it. Some evaluations have automatic control off, to catch a design that skips the accumulation. Some inject a second strobe while busy, to catch a design that accepts it and inflates the next snapshot.

// File: rtl/immunity_eval_pkg.sv
package immunity_eval_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DIV    = 2'd1,
        ST_DECIDE = 2'd2
    } eval_state_e;

    // Order of the limits as they are computed; the decision logic indexes by it
    localparam int unsigned LIM_OFDM_HI = 0;
    localparam int unsigned LIM_CCK_HI  = 1;
    localparam int unsigned LIM_OFDM_LO = 2;
    localparam int unsigned LIM_CCK_LO  = 3;
    localparam int unsigned N_LIMITS    = 4;

    typedef struct packed {
        logic raise;
        logic ofdm_hit;
        logic lower;
        logic restart;
    } verdict_t;

endpackage

// File: rtl/immunity_div.sv
module immunity_div #(
    parameter int NUM_W = 30,
    parameter int DEN_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quot
);
    localparam int CNT_W = $clog2(NUM_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_W - 1);

    logic [NUM_W-1:0] q_r;
    logic [DEN_W-1:0] rem_r;
    logic [CNT_W-1:0] cnt_r;
    logic             run_r;
    logic [DEN_W:0]   trial;
    logic [DEN_W:0]   diff;
    logic             fits;

    always_comb begin
        trial = {rem_r, q_r[NUM_W-1]};
        fits  = (trial >= {1'b0, den});
        diff  = trial - {1'b0, den};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r   <= '0;
            rem_r <= '0;
            cnt_r <= '0;
            run_r <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                q_r   <= num;
                rem_r <= '0;
                cnt_r <= '0;
                run_r <= 1'b1;
            end else if (run_r) begin
                q_r   <= {q_r[NUM_W-2:0], fits};
                rem_r <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
                if (cnt_r == LAST) begin
                    run_r <= 1'b0;
                    done  <= 1'b1;
                end else begin
                    cnt_r <= cnt_r + 1'b1;
                end
            end
        end
    end

    assign quot = q_r;

endmodule

// File: rtl/immunity_decide.sv
module immunity_decide
    import immunity_eval_pkg::*;
#(
    parameter int          ERR_W    = 16,
    parameter int          ACC_W    = 20,
    parameter int          Q_W      = 30,
    parameter int unsigned QUIET_MS = 500
) (
    input  logic [ERR_W-1:0]                ofdm_cnt,
    input  logic [ERR_W-1:0]                cck_cnt,
    input  logic [ACC_W-1:0]                listen_total,
    input  logic [N_LIMITS-1:0][Q_W-1:0]    limits,
    output verdict_t                        verdict
);
    logic ofdm_over, cck_over, ofdm_calm, cck_calm, quiet;

    always_comb begin
        ofdm_over = Q_W'(ofdm_cnt) > limits[LIM_OFDM_HI];
        cck_over  = Q_W'(cck_cnt)  > limits[LIM_CCK_HI];
        ofdm_calm = Q_W'(ofdm_cnt) <= limits[LIM_OFDM_LO];
        cck_calm  = Q_W'(cck_cnt)  <= limits[LIM_CCK_LO];
        quiet     = 32'(listen_total) > 32'(QUIET_MS);

        verdict.raise    = ofdm_over | cck_over;
        verdict.ofdm_hit = ofdm_over;
        verdict.lower    = !verdict.raise && quiet && ofdm_calm && cck_calm;
        verdict.restart  = verdict.raise | quiet;
    end

endmodule

// File: rtl/immunity_eval.sv
module immunity_eval
    import immunity_eval_pkg::*;
#(
    parameter int          LISTEN_W         = 16,
    parameter int          ERR_W            = 16,
    parameter int          ACC_W            = 20,
    parameter int          RATE_W           = 10,
    parameter int unsigned OFDM_HI_RATE     = 500,
    parameter int unsigned CCK_HI_RATE      = 200,
    parameter int unsigned OFDM_LO_RATE     = 200,
    parameter int unsigned CCK_LO_RATE      = 100,
    parameter int unsigned LISTEN_PERIOD_MS = 100,
    parameter int unsigned QUIET_PERIODS    = 5,
    parameter int unsigned MS_PER_S         = 1000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                eval_strobe_i,
    input  logic [LISTEN_W-1:0] listen_ms_i,
    input  logic [ERR_W-1:0]    ofdm_err_i,
    input  logic [ERR_W-1:0]    cck_err_i,
    input  logic                auto_en_i,
    output logic                busy_o,
    output logic                raise_o,
    output logic                raise_ofdm_o,
    output logic                lower_o,
    output logic                restart_o,
    output logic [ACC_W-1:0]    snap_listen_o,
    output logic [ERR_W-1:0]    snap_ofdm_o,
    output logic [ERR_W-1:0]    snap_cck_o
);
    localparam int PROD_W = ACC_W + RATE_W;
    localparam int DEN_W  = $clog2(MS_PER_S + 1);
    localparam int unsigned QUIET_MS = QUIET_PERIODS * LISTEN_PERIOD_MS;
    localparam logic [RATE_W-1:0] RATE_TAB [N_LIMITS] = '{
        RATE_W'(OFDM_HI_RATE), RATE_W'(CCK_HI_RATE),
        RATE_W'(OFDM_LO_RATE), RATE_W'(CCK_LO_RATE)
    };
    localparam logic [1:0] LAST_LIM = 2'(N_LIMITS - 1);

    eval_state_e                   state_r;
    logic [1:0]                    lim_idx_r;
    logic [ACC_W-1:0]              acc_r;
    logic [ERR_W-1:0]              ofdm_r, cck_r;
    logic [N_LIMITS-1:0][PROD_W-1:0] lim_r;
    logic                          div_start_r;
    logic                          div_done;
    logic [PROD_W-1:0]             div_q;
    logic [PROD_W-1:0]             dividend;
    logic [ACC_W:0]                acc_sum;
    logic [ACC_W-1:0]              acc_next;
    verdict_t                      verdict;

    // saturating accumulation of listen time
    always_comb begin
        acc_sum  = {1'b0, acc_r} + (ACC_W+1)'(listen_ms_i);
        acc_next = acc_sum[ACC_W] ? '1 : acc_sum[ACC_W-1:0];
        dividend = PROD_W'(acc_r) * PROD_W'(RATE_TAB[lim_idx_r]);
    end

    immunity_div #(
        .NUM_W (PROD_W),
        .DEN_W (DEN_W)
    ) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (div_start_r),
        .num   (dividend),
        .den   (DEN_W'(MS_PER_S)),
        .done  (div_done),
        .quot  (div_q)
    );

    for (genvar g = 0; g < N_LIMITS; g++) begin : g_limit
        always_ff @(posedge clk) begin
            if (rst) begin
                lim_r[g] <= '0;
            end else if (state_r == ST_DIV && div_done && lim_idx_r == 2'(g)) begin
                lim_r[g] <= div_q;
            end
        end
    end

    immunity_decide #(
        .ERR_W    (ERR_W),
        .ACC_W    (ACC_W),
        .Q_W      (PROD_W),
        .QUIET_MS (QUIET_MS)
    ) u_decide (
        .ofdm_cnt     (ofdm_r),
        .cck_cnt      (cck_r),
        .listen_total (acc_r),
        .limits       (lim_r),
        .verdict      (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_r       <= ST_IDLE;
            lim_idx_r     <= '0;
            acc_r         <= '0;
            ofdm_r        <= '0;
            cck_r         <= '0;
            div_start_r   <= 1'b0;
            raise_o       <= 1'b0;
            raise_ofdm_o  <= 1'b0;
            lower_o       <= 1'b0;
            restart_o     <= 1'b0;
            snap_listen_o <= '0;
            snap_ofdm_o   <= '0;
            snap_cck_o    <= '0;
        end else begin
            div_start_r  <= 1'b0;
            raise_o      <= 1'b0;
            raise_ofdm_o <= 1'b0;
            lower_o      <= 1'b0;
            restart_o    <= 1'b0;
            unique case (state_r)
                ST_IDLE: begin
                    if (eval_strobe_i) begin
                        acc_r <= acc_next;
                        if (auto_en_i) begin
                            ofdm_r      <= ofdm_err_i;
                            cck_r       <= cck_err_i;
                            lim_idx_r   <= '0;
                            div_start_r <= 1'b1;
                            state_r     <= ST_DIV;
                        end
                    end
                end
                ST_DIV: begin
                    if (div_done) begin
                        if (lim_idx_r == LAST_LIM) begin
                            state_r <= ST_DECIDE;
                        end else begin
                            lim_idx_r   <= lim_idx_r + 1'b1;
                            div_start_r <= 1'b1;
                        end
                    end
                end
                ST_DECIDE: begin
                    raise_o      <= verdict.raise;
                    raise_ofdm_o <= verdict.ofdm_hit;
                    lower_o      <= verdict.lower;
                    restart_o    <= verdict.restart;
                    if (verdict.restart) begin
                        snap_listen_o <= acc_r;
                        snap_ofdm_o   <= ofdm_r;
                        snap_cck_o    <= cck_r;
                        acc_r         <= '0;
                    end
                    state_r <= ST_IDLE;
                end
                default: state_r <= ST_IDLE;
            endcase
        end
    end

    assign busy_o = (state_r != ST_IDLE);

endmodule

// File: rtl/immunity_eval_chk.sv
module immunity_eval_chk #(
    parameter int ACC_W = 20
) (
    input logic             clk,
    input logic             rst,
    input logic             busy_o,
    input logic             raise_o,
    input logic             raise_ofdm_o,
    input logic             lower_o,
    input logic             restart_o,
    input logic [ACC_W-1:0] snap_listen_o
);
    // R9
    excl_decision_chk: assert property (@(posedge clk) disable iff (rst)
        !(raise_o && lower_o));

    // R9
    raise_restart_chk: assert property (@(posedge clk) disable iff (rst)
        raise_o |-> restart_o);

    // R5
    lower_restart_chk: assert property (@(posedge clk) disable iff (rst)
        lower_o |-> restart_o);

    // R4
    ofdm_flag_chk: assert property (@(posedge clk) disable iff (rst)
        raise_ofdm_o |-> raise_o);

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        restart_o |=> !restart_o);

    // R8
    idle_at_decision_chk: assert property (@(posedge clk) disable iff (rst)
        restart_o |-> !busy_o);

    // R7
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !restart_o |-> $stable(snap_listen_o));

endmodule

bind immunity_eval immunity_eval_chk #(.ACC_W(ACC_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .busy_o        (busy_o),
    .raise_o       (raise_o),
    .raise_ofdm_o  (raise_ofdm_o),
    .lower_o       (lower_o),
    .restart_o     (restart_o),
    .snap_listen_o (snap_listen_o)
);

// File: tb/immunity_eval_tb.sv
module immunity_eval_tb;
    localparam int LISTEN_W = 16;
    localparam int ERR_W    = 16;
    localparam int ACC_W    = 20;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                eval_strobe_i = 1'b0;
    logic [LISTEN_W-1:0] listen_ms_i = '0;
    logic [ERR_W-1:0]    ofdm_err_i = '0;
    logic [ERR_W-1:0]    cck_err_i = '0;
    logic                auto_en_i = 1'b0;
    logic                busy_o, raise_o, raise_ofdm_o, lower_o, restart_o;
    logic [ACC_W-1:0]    snap_listen_o;
    logic [ERR_W-1:0]    snap_ofdm_o, snap_cck_o;

    int checks = 0;
    int fails  = 0;
    int n_raise, n_flag, n_lower, n_restart;
    longint acc_m = 0;
    longint s_listen = 0, s_ofdm = 0, s_cck = 0;

    always #5 clk = ~clk;

    immunity_eval u_dut (
        .clk           (clk),
        .rst           (rst),
        .eval_strobe_i (eval_strobe_i),
        .listen_ms_i   (listen_ms_i),
        .ofdm_err_i    (ofdm_err_i),
        .cck_err_i     (cck_err_i),
        .auto_en_i     (auto_en_i),
        .busy_o        (busy_o),
        .raise_o       (raise_o),
        .raise_ofdm_o  (raise_ofdm_o),
        .lower_o       (lower_o),
        .restart_o     (restart_o),
        .snap_listen_o (snap_listen_o),
        .snap_ofdm_o   (snap_ofdm_o),
        .snap_cck_o    (snap_cck_o)
    );

    always @(negedge clk) begin
        if (raise_o)      n_raise++;
        if (raise_ofdm_o) n_flag++;
        if (lower_o)      n_lower++;
        if (restart_o)    n_restart++;
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint lim(input longint t, input longint rate);
        return (t * rate) / 1000;
    endfunction

    function automatic longint clampc(input longint v);
        if (v < 0) return 0;
        if (v > 65535) return 65535;
        return v;
    endfunction

    task automatic evaluate(input int listen, input longint o, input longint c,
                            input bit auto_on, input bit inject);
        longint t, oh, ch, ol, cl;
        bit e_raise, e_flag, e_lower, e_restart, quiet;
        t  = acc_m + listen;
        oh = lim(t, 500); ch = lim(t, 200); ol = lim(t, 200); cl = lim(t, 100);
        quiet     = (t > 500);
        e_flag    = auto_on && (o > oh);
        e_raise   = auto_on && ((o > oh) || (c > ch));
        e_lower   = auto_on && !e_raise && quiet && (o <= ol) && (c <= cl);
        e_restart = auto_on && (e_raise || quiet);
        n_raise = 0; n_flag = 0; n_lower = 0; n_restart = 0;
        @(negedge clk);
        eval_strobe_i = 1'b1;
        listen_ms_i   = LISTEN_W'(listen);
        ofdm_err_i    = ERR_W'(o);
        cck_err_i     = ERR_W'(c);
        auto_en_i     = auto_on;
        @(negedge clk);
        eval_strobe_i = 1'b0;
        if (auto_on) chk("R8 busy after auto strobe", busy_o, 1);
        else         chk("R2 not busy in manual", busy_o, 0);
        if (inject && auto_on) begin
            eval_strobe_i = 1'b1;
            listen_ms_i   = 16'd777;
            ofdm_err_i    = 16'hFFFF;
            cck_err_i     = 16'hFFFF;
            @(negedge clk);
            eval_strobe_i = 1'b0;
        end
        for (int k = 0; k < 1000 && busy_o; k++) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        acc_m = t;
        chk(auto_on ? "R4 raise" : "R2 no raise in manual", n_raise, e_raise);
        chk("R4 ofdm flag", n_flag, e_flag);
        chk(auto_on ? "R5 lower" : "R2 no lower in manual", n_lower, e_lower);
        chk(quiet ? "R5 restart" : "R6 restart", n_restart, e_restart);
        if (e_restart) begin
            s_listen = t; s_ofdm = o; s_cck = c; acc_m = 0;
            chk("R7 snapshot listen (R3 total)", snap_listen_o, s_listen);
            chk("R7 snapshot ofdm", snap_ofdm_o, s_ofdm);
            chk("R7 snapshot cck", snap_cck_o, s_cck);
        end else begin
            chk("R6 snapshot unchanged", snap_listen_o, s_listen);
            chk("R6 snapshot ofdm unchanged", snap_ofdm_o, s_ofdm);
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy_o, 0);
        chk("R1 raise", raise_o, 0);
        chk("R1 lower", lower_o, 0);
        chk("R1 restart", restart_o, 0);
        chk("R1 snap listen", snap_listen_o, 0);
        chk("R1 snap ofdm", snap_ofdm_o, 0);
        chk("R1 snap cck", snap_cck_o, 0);

        // R2 manual accumulation feeds the next automatic evaluation
        evaluate(300, 0, 0, 1'b0, 1'b0);
        evaluate(250, 0, 0, 1'b1, 1'b0);   // total 550: quiet, lower

        for (int i = 0; i < 240; i++) begin
            int     listen;
            bit     au, inj;
            longint t, o, c;
            int     d;
            listen = ((i * 53) % 260) + 1;
            au     = (i % 9) != 4;
            inj    = (i % 11) == 6;
            t      = acc_m + listen;
            d      = (i / 5) % 3;
            case (i % 5)
                0: begin o = lim(t, 500) + d - 1; c = 0; end
                1: begin o = 0; c = lim(t, 200) + d - 1; end
                2: begin o = lim(t, 200) + ((i / 5) % 2); c = lim(t, 100) + ((i / 10) % 2); end
                3: begin o = 0; c = 0; end
                default: begin o = lim(t, 500) + 1; c = lim(t, 200) + 1; end
            endcase
            // R3 limits sit at floor(t*rate/1000); counts straddle them
            evaluate(listen, clampc(o), clampc(c), au, inj);
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule